// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between synchronous logic and a one-bit-wide asynchronous static RAM with a 20-bit address. The RAM has its own data-in pin and its own data-out pin, active-low chip select and active-low write enable, and no output-enable pin. On the user side a request lasts a single clock cycle and carries an address, a write flag and one data bit. The controller drives the RAM pins through the required timing sequence and answers with a one-cycle done pulse. For a read, the done pulse comes with the captured bit.

All analog timing limits are parameters in nanoseconds, together with the clock period. The controller turns them into whole clock-cycle counts. It runs one operation at a time. It shows on `ready` when it can take a request and ignores any request that arrives while it is busy.

A write uses a strobe controlled by write enable. Address and data are registered and chip select falls one cycle before write enable goes low. Both are held one cycle after write enable rises, and chip select then returns high. A read lowers chip select with write enable held high. It waits out the access time and samples the data-out pin on the final wait cycle.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `mem_cs_n` and `mem_we_n` are 1, `done` is 0 and `ready` is 1.
- R2: `ready` is high only when the controller is idle. A request with `req_valid` high while `ready` is low is ignored: it produces no `done` and does not change the RAM contents.
- R3: A write drives `mem_we_n` low for exactly `WP_CYC` consecutive cycles (2 with default parameters). `mem_cs_n` is low during the whole strobe, during the cycle before it and during the cycle after it.
- R4: `mem_addr` and `mem_d` stay constant for as long as `mem_cs_n` is low, from before the strobe falls until after it rises.
- R5: A read keeps `mem_we_n` high. It samples `mem_q` `RD_CYC` cycles after `mem_cs_n` falls (2 with default parameters). `rd_data` then holds that bit until the next read completes.
- R6: `done` is a single-cycle pulse. For a read it is high `RD_CYC` cycles after the accepting clock edge. For a write it is high `WP_CYC + 2` cycles after that edge.
- R7: `mem_cs_n` is back at 1 in the cycle in which `done` is high. Whenever `ready` is high, `mem_cs_n` is 1.
- R8: `WP_CYC` is the smallest k ≥ 1 that meets all four of these conditions: k·T_CLK ≥ strobe minimum, k·T_CLK ≥ data-setup minimum, (k+1)·T_CLK ≥ address-valid-to-end minimum, and (k+2)·T_CLK ≥ write-cycle minimum. `RD_CYC` is the smallest k ≥ 1 with k·T_CLK ≥ both the access time and the read-cycle minimum.
- R9: A new request can be accepted in the same cycle that `done` of the previous operation is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 1 | Write data bit |
| ready | output | 1 | Idle, request will be taken |
| done | output | 1 | Operation complete pulse |
| rd_data | output | 1 | Bit captured by the last read |
| mem_addr | output | 20 | RAM address pins |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_d | output | 1 | RAM data-in pin |
| mem_q | input | 1 | RAM data-out pin |

## Verification
The hardest case to reach is a read whose data is sampled too early. With an ideal zero-delay memory, a shortened wait would look correct. The bench memory model therefore drives the inverted bit on its data-out pin until the access time has passed since the last change of address, chip select or write enable. An early sample then shows up as wrong read data. The ignored-request case needs a request placed in the middle of a write strobe. That request targets a different address, and that address is read back later.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_WAIT,
    S_WR_SETUP,
    S_WR_STROBE,
    S_WR_HOLD
  } asram_state_e;

  // cycles needed to cover t_ns, rounded up
  function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sub_sat(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  // strobe length: address valid one cycle before, cycle has one setup and one hold cycle
  function automatic int unsigned strobe_cycles(int unsigned t_wp, int unsigned t_dw,
                                                int unsigned t_aw, int unsigned t_wc,
                                                int unsigned clk_ns);
    int unsigned k;
    k = max_u(ns_to_cyc(t_wp, clk_ns), ns_to_cyc(t_dw, clk_ns));
    k = max_u(k, sub_sat(ns_to_cyc(t_aw, clk_ns), 1));
    k = max_u(k, sub_sat(ns_to_cyc(t_wc, clk_ns), 2));
    return max_u(k, 1);
  endfunction

  function automatic int unsigned read_cycles(int unsigned t_aa, int unsigned t_rc,
                                              int unsigned clk_ns);
    return max_u(max_u(ns_to_cyc(t_aa, clk_ns), ns_to_cyc(t_rc, clk_ns)), 1);
  endfunction

  function automatic int unsigned cnt_width(int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val);
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  p_timer_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  p_timer_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             ready,
  output logic             accept,
  output logic             strobe_start,
  output logic             strobe_end,
  output logic             sample_now,
  output logic             finish,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

  asram_state_e st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:      if (req_valid) st_nx = req_write ? S_WR_SETUP : S_RD_WAIT;
      S_RD_WAIT:   if (tmr_zero)  st_nx = S_IDLE;
      S_WR_SETUP:                 st_nx = S_WR_STROBE;
      S_WR_STROBE: if (tmr_zero)  st_nx = S_WR_HOLD;
      S_WR_HOLD:                  st_nx = S_IDLE;
      default:                    st_nx = S_IDLE;
    endcase
  end

  // named events for pin logic and assertions
  assign ready        = (st == S_IDLE);
  assign accept       = ready && req_valid;
  assign strobe_start = (st == S_WR_SETUP);
  assign strobe_end   = (st == S_WR_STROBE) && tmr_zero;
  assign sample_now   = (st == S_RD_WAIT) && tmr_zero;
  assign finish       = (st == S_WR_HOLD) || sample_now;

  assign tmr_load = accept || strobe_start;
  assign tmr_val  = strobe_start ? WP_LOAD : RD_LOAD;

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready);

  p_setup_then_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> strobe_start);

endmodule

// File: rtl/asram_pinreg.sv
`timescale 1ns/1ps
module asram_pinreg #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned WP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              strobe_start,
  input  logic              strobe_end,
  input  logic              sample_now,
  input  logic              finish,
  input  logic              mem_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_d,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              rd_data,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_d    <= 1'b0;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      rd_data  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        mem_addr <= req_addr;
        mem_d    <= req_wdata;
        mem_cs_n <= 1'b0;
      end
      if (strobe_start) mem_we_n <= 1'b0;
      if (strobe_end)   mem_we_n <= 1'b1;
      if (finish)       mem_cs_n <= 1'b1;
      if (sample_now)   rd_data  <= mem_q;
    end
  end

  // strobe length observer for the assertion below
  logic [15:0] we_low_len;
  always_ff @(posedge clk) begin
    if (rst)            we_low_len <= '0;
    else if (!mem_we_n) we_low_len <= we_low_len + 16'd1;
    else                we_low_len <= '0;
  end

  p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  p_cs_before_we_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_len == 16'(WP_CYC)) && !mem_cs_n);

  p_pins_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |=> ($stable(mem_addr) && $stable(mem_d)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_WP_NS = 15,
  parameter int unsigned T_AW_NS = 16,
  parameter int unsigned T_DW_NS = 12,
  parameter int unsigned T_WC_NS = 20,
  parameter int unsigned T_AA_NS = 20,
  parameter int unsigned T_RC_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              ready,
  output logic              done,
  output logic              rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_d,
  input  logic              mem_q
);

  localparam int unsigned WP_CYC = strobe_cycles(T_WP_NS, T_DW_NS, T_AW_NS, T_WC_NS, CLK_NS);
  localparam int unsigned RD_CYC = read_cycles(T_AA_NS, T_RC_NS, CLK_NS);
  localparam int unsigned CNT_W  = cnt_width(max_u(WP_CYC, RD_CYC));

  logic             accept, strobe_start, strobe_end, sample_now, finish;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  asram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .tmr_zero(tmr_zero), .ready(ready), .accept(accept),
    .strobe_start(strobe_start), .strobe_end(strobe_end),
    .sample_now(sample_now), .finish(finish),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  asram_pinreg #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .strobe_start(strobe_start),
    .strobe_end(strobe_end), .sample_now(sample_now), .finish(finish),
    .mem_q(mem_q), .mem_addr(mem_addr), .mem_d(mem_d),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .rd_data(rd_data), .done(done)
  );

  p_ready_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
    ready |-> mem_cs_n);

  p_read_we_high_r5: assert property (@(posedge clk) disable iff (rst)
    sample_now |-> (mem_we_n && !mem_cs_n));

  p_done_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> mem_cs_n);

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_WP = 15, T_AW = 16, T_DW = 12, T_WC = 20, T_AA = 20, T_RC = 20;

  // bench's own restatement of R8
  function automatic int exp_wp();
    for (int k = 1; k < 1000; k++)
      if (k*CLK_PERIOD >= T_WP && k*CLK_PERIOD >= T_DW &&
          (k+1)*CLK_PERIOD >= T_AW && (k+2)*CLK_PERIOD >= T_WC) return k;
    return -1;
  endfunction
  function automatic int exp_rd();
    for (int k = 1; k < 1000; k++)
      if (k*CLK_PERIOD >= T_AA && k*CLK_PERIOD >= T_RC) return k;
    return -1;
  endfunction
  localparam int EXP_WP = exp_wp();
  localparam int EXP_RD = exp_rd();

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0, req_wdata = 0;
  logic [19:0] req_addr = '0;
  logic        ready, done, rd_data, mem_cs_n, mem_we_n, mem_d, mem_q;
  logic [19:0] mem_addr;

  asram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_d(mem_d), .mem_q(mem_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- memory model ----------------
  bit mem [int unsigned];
  int mem_rev = 0, gen = 0;
  bit q_ok = 0;
  logic q_drv;

  function automatic bit model_rd(logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 1'b0;
  endfunction

  // data-out only correct once access time has elapsed since the last change
  always @(mem_addr or mem_cs_n or mem_we_n) begin
    gen = gen + 1;
    q_ok = 1'b0;
    fork
      begin
        automatic int my = gen;
        #(T_AA - 1);
        if (my == gen) q_ok = 1'b1;
      end
    join_none
  end

  always @(mem_addr or mem_cs_n or mem_we_n or q_ok or mem_rev) begin
    bit v;
    v = model_rd(mem_addr);
    q_drv = (!mem_cs_n && mem_we_n && q_ok) ? v : ~v;
  end
  assign mem_q = q_drv;

  int          low_cnt = 0;
  logic [19:0] st_addr;
  bit          st_d, cs_prev = 1;
  always @(posedge clk) begin
    if (!rst) begin
      if (!mem_cs_n && !mem_we_n) begin
        if (low_cnt == 0) begin
          st_addr = mem_addr; st_d = mem_d;
          chk(cs_prev == 0, "R3 cs low before strobe", cs_prev, 0);
        end else begin
          chk(mem_addr == st_addr && mem_d == st_d, "R4 pins moved in strobe",
              int'(mem_addr), int'(st_addr));
        end
        low_cnt++;
      end else if (low_cnt != 0) begin
        chk(low_cnt == EXP_WP, "R3 strobe width", low_cnt, EXP_WP);
        chk(!mem_cs_n && mem_addr == st_addr && mem_d == st_d,
            "R4 hold after strobe", int'(mem_addr), int'(st_addr));
        mem[int'(st_addr)] = st_d;
        mem_rev++;
        low_cnt = 0;
      end
    end
    cs_prev = mem_cs_n;
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; bit val; int acc; int lat; } exp_t;
  exp_t sb[$];
  bit shadow [int unsigned];

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(0, "R2 done with no accepted request", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc - e.acc == e.lat, e.wr ? "R6 R8 write latency" : "R6 R8 read latency",
            cyc - e.acc, e.lat);
        if (!e.wr) chk(rd_data == e.val, "R5 read data", rd_data, e.val);
        chk(mem_cs_n == 1, "R7 cs high with done", mem_cs_n, 1);
      end
    end
  end

  task automatic issue(bit wr, logic [19:0] a, bit d, bit b2b);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    if (b2b) chk(done == 1, "R9 accept in done cycle", done, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    e.wr  = wr;
    e.acc = cyc;
    e.lat = wr ? EXP_WP + 2 : EXP_RD;
    if (wr) begin
      shadow[int'(a)] = d;
      e.val = d;
    end else begin
      e.val = shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0;
    end
    sb.push_back(e);
  endtask

  // request while busy: must be dropped
  task automatic poke_busy(logic [19:0] a, bit d);
    @(negedge clk);
    chk(ready == 0, "R2 ready low while busy", ready, 0);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(mem_cs_n == 1, "R1 cs after reset", mem_cs_n, 1);
    chk(mem_we_n == 1, "R1 we after reset", mem_we_n, 1);
    chk(done == 0, "R1 done after reset", done, 0);
    chk(ready == 1, "R1 ready after reset", ready, 1);

    // writes at spread addresses, including top address bits
    issue(1, 20'h00012, 1, 0);
    issue(1, 20'h80012, 0, 0);
    issue(1, 20'hFFFFF, 1, 0);
    issue(1, 20'h00000, 1, 0);
    issue(0, 20'h00012, 0, 0);
    issue(0, 20'h80012, 0, 0);
    issue(0, 20'hFFFFF, 0, 0);
    issue(0, 20'h00000, 0, 0);

    // ignored request during a write
    issue(1, 20'h0A5A5, 0, 0);
    poke_busy(20'h12345, 1);
    issue(0, 20'h12345, 0, 0);
    issue(0, 20'h0A5A5, 0, 0);

    // ignored request during a read
    issue(0, 20'hFFFFF, 0, 0);
    poke_busy(20'hFFFFF, 0);
    issue(0, 20'hFFFFF, 0, 0);

    // back-to-back: write then read, read then write
    issue(1, 20'h55555, 1, 0);
    issue(0, 20'h55555, 0, 1);
    issue(1, 20'h55555, 0, 1);
    issue(0, 20'h55555, 0, 1);
    issue(0, 20'h00012, 0, 1);

    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R6 all operations completed", sb.size(), 0);
    chk(ready == 1 && mem_cs_n == 1, "R7 idle with cs high", mem_cs_n, 1);
    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    wrap_up();
  end

endmodule